// File: doc/BRIEF.md
# Interrupt Mask and DMA Steering

This block collects thirteen interrupt sources of a card host controller into a request register and combines them with a software mask to drive one level-sensitive CPU interrupt. The card data path and the command engine are outside the block. They deliver one-cycle event pulses, and each pulse sets the matching request bit. A request bit stays set until a specific register access clears it.

A DMA-enable control bit changes where the two FIFO service requests go. While DMA is on, the receive and transmit FIFO requests are always hidden from the CPU interrupt and appear on two separate DMA request lines. While DMA is off, they behave like every other maskable source.

The block also owns the card clock start/stop control. Stopping the clock clears the clock-enable status, raises the clock-off request and pulses an abort toward the transfer logic. Starting the clock reverses the first two effects. All registers are reached through a simple single-cycle word-addressed bus.

Top module: `irq_dma_router`

## Requirements
- R1: After reset the request register, the mask, the clock-enable status and the DMA-enable bit are all zero, and `cpu_irq`, `rx_dma_req`, `tx_dma_req` and `xfer_abort` are low.
- R2: A pulse on `evt_set[i]` sets request bit i at the next clock edge, and the bit stays set until it is cleared. The bit meanings are: 0 data done, 1 programming done, 2 end of command, 3 stop command, 4 clock off, 5 RX FIFO service, 6 TX FIFO service, 7 transfer timer, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge.
- R3: A write to the mask register (word address 3) stores only write-data bits 12:0, and a read of address 3 returns them zero-extended. A set mask bit hides the matching request from the CPU interrupt.
- R4: `cpu_irq` is registered. In the cycle after any clock edge, it is high exactly when the request register held before that edge had a bit set that the effective mask of that cycle does not cover.
- R5: When the DMA-enable bit (bit 7 of the control register, word address 2) is set, the effective mask also covers request bits 5 and 6. `rx_dma_req` then follows bit 5 and `tx_dma_req` follows bit 6, with the same one-cycle registration as R4.
- R6: When the DMA-enable bit is clear, `rx_dma_req` and `tx_dma_req` are low.
- R7: A write to the clock control register (word address 0) with data bit 0 set does three things at that edge: it clears the clock-enable status (bit 8 of the status register, word address 1, also on `clk_en`), and it sets request bit 4. In the next cycle `xfer_abort` is high for one cycle.
- R8: A write to address 0 with data bit 1 set, and bit 0 clear, sets the clock-enable status and clears request bit 4. If both bits are set in one write, the stop effects of R7 win.
- R9: Three accesses clear request bits. A read of the receive data port (address 5) clears bit 5. A write to the transmit data port (address 6) clears bit 6. A write to the request register (address 4) clears every bit written as 1.
- R10: If an event pulse or a stop-clock write sets a request bit in the same cycle as an access clears it, the bit ends up set.
- R11: Reads return 0 for addresses 0, 5, 6 and every unused address. Address 1 returns the clock-enable status at bit 8, address 2 returns DMA-enable at bit 7, and address 4 returns the request register at bits 12:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the receive data port) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the current state |
| evt_set | input | NREQ | One-cycle event pulses, one for each request bit |
| cpu_irq | output | 1 | Level interrupt to the CPU |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| xfer_abort | output | 1 | One-cycle abort pulse after a stop-clock write |
| clk_en | output | 1 | Clock-enable status |

## Verification
Two cases can land on one request bit in the same cycle: an event pulse that sets the bit and a bus access that clears it. The same happens when a combined start/stop clock write both clears and sets the clock-off bit. The bench forces these collisions on purpose. It pulses event 5 during a receive-port read, event 6 during a transmit-port write, and a full event vector during a write-one-to-clear of all ones. The random phase then produces many more such collisions. In each case the bench reads the request register back through the bus, and it judges the cpu_irq and DMA lines in the following cycle against its own model, in which set takes priority over clear.

// File: rtl/irq_dma_router.sv
module irq_dma_router #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NREQ      = 13,
  parameter int CLKEN_POS = 8,
  parameter int DMAEN_POS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NREQ-1:0]   evt_set,
  output logic              cpu_irq,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              xfer_abort,
  output logic              clk_en
);

  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_REQ  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(6);

  localparam int B_CLKOFF = 4;
  localparam int B_RXF    = 5;
  localparam int B_TXF    = 6;
  localparam logic [NREQ-1:0] FIFO_BITS =
    (NREQ'(1) << B_RXF) | (NREQ'(1) << B_TXF);

  logic [NREQ-1:0] req_q, mask_q, req_nxt, set_v, clr_v, eff_mask;
  logic            dma_en_q, clk_en_q;
  logic            wr_clk, stop_w, start_w;
  logic            unused_wbits;

  assign unused_wbits = ^bus_wdata;

  assign wr_clk  = bus_wr && (bus_addr == A_CLK);
  assign stop_w  = wr_clk && bus_wdata[0];
  assign start_w = wr_clk && bus_wdata[1];

  always_comb begin
    set_v = evt_set;
    if (stop_w) set_v[B_CLKOFF] = 1'b1;
    clr_v = '0;
    if (bus_wr && bus_addr == A_REQ) clr_v = bus_wdata[NREQ-1:0];
    if (start_w) clr_v[B_CLKOFF] = 1'b1;
    if (bus_rd && bus_addr == A_RXD) clr_v[B_RXF] = 1'b1;
    if (bus_wr && bus_addr == A_TXD) clr_v[B_TXF] = 1'b1;
    req_nxt = (req_q & ~clr_v) | set_v;
  end

  assign eff_mask = mask_q | (dma_en_q ? FIFO_BITS : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q      <= '0;
      mask_q     <= '0;
      dma_en_q   <= 1'b0;
      clk_en_q   <= 1'b0;
      cpu_irq    <= 1'b0;
      rx_dma_req <= 1'b0;
      tx_dma_req <= 1'b0;
      xfer_abort <= 1'b0;
    end else begin
      req_q <= req_nxt;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[NREQ-1:0];
      if (bus_wr && bus_addr == A_CTRL) dma_en_q <= bus_wdata[DMAEN_POS];
      if (stop_w)       clk_en_q <= 1'b0;
      else if (start_w) clk_en_q <= 1'b1;
      cpu_irq    <= |(req_q & ~eff_mask);
      rx_dma_req <= dma_en_q && req_q[B_RXF];
      tx_dma_req <= dma_en_q && req_q[B_TXF];
      xfer_abort <= stop_w;
    end
  end

  assign clk_en = clk_en_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT: bus_rdata[CLKEN_POS] = clk_en_q;
      A_CTRL: bus_rdata[DMAEN_POS] = dma_en_q;
      A_MASK: bus_rdata[NREQ-1:0]  = mask_q;
      A_REQ:  bus_rdata[NREQ-1:0]  = req_q;
      default: bus_rdata = '0;
    endcase
  end

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((req_q & $past(evt_set)) == $past(evt_set)));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RXD && evt_set[B_RXF]) |=> req_q[B_RXF]);

  p_mask_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK) |=> (mask_q == $past(bus_wdata[NREQ-1:0])));

  p_unmasked_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~mask_q & ~FIFO_BITS) != '0) |=> cpu_irq);

  p_dma_steer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en_q && (req_q & ~mask_q & ~FIFO_BITS) == '0) |=> !cpu_irq);

  p_dma_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en_q |=> (!rx_dma_req && !tx_dma_req));

  p_stop_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> (!clk_en && req_q[B_CLKOFF] && xfer_abort));

  p_start_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && !stop_w && !evt_set[B_CLKOFF]) |=> (clk_en && !req_q[B_CLKOFF]));

endmodule

// File: tb/irq_dma_router_tb.sv
module irq_dma_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [12:0] evt_set = '0;
  logic        cpu_irq, rx_dma_req, tx_dma_req, xfer_abort, clk_en;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [12:0] m_req = '0, m_mask = '0;
  logic        m_dma = 0, m_clk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dma_router dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .cpu_irq(cpu_irq), .rx_dma_req(rx_dma_req),
    .tx_dma_req(tx_dma_req), .xfer_abort(xfer_abort), .clk_en(clk_en));

  function automatic logic exp_irq(logic [12:0] r, logic [12:0] m, logic d);
    logic [12:0] em = m | (d ? 13'h0060 : 13'h0);
    return |(r & ~em);
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a)
      4'd1: return {23'd0, m_clk, 8'd0};
      4'd2: return {24'd0, m_dma, 7'd0};
      4'd3: return {19'd0, m_mask};
      4'd4: return {19'd0, m_req};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic wr, logic rd, logic [3:0] a, logic [31:0] d, logic [12:0] ev);
    logic e_irq, e_rx, e_tx, e_ab, stop, start;
    logic [12:0] setv, clrv;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; evt_set = ev;
    #1;
    if (rd) chk("R11 R3 R9 read data", bus_rdata, exp_read(a));
    @(posedge clk); #1;
    e_irq = exp_irq(m_req, m_mask, m_dma);
    e_rx  = m_dma & m_req[5];
    e_tx  = m_dma & m_req[6];
    stop  = wr && a == 4'd0 && d[0];
    start = wr && a == 4'd0 && d[1];
    e_ab  = stop;
    setv = ev; if (stop) setv[4] = 1'b1;
    clrv = '0;
    if (wr && a == 4'd4) clrv = d[12:0];
    if (start) clrv[4] = 1'b1;
    if (rd && a == 4'd5) clrv[5] = 1'b1;
    if (wr && a == 4'd6) clrv[6] = 1'b1;
    m_req = (m_req & ~clrv) | setv;
    if (wr && a == 4'd3) m_mask = d[12:0];
    if (wr && a == 4'd2) m_dma = d[7];
    if (stop) m_clk = 0; else if (start) m_clk = 1;
    chk("R4 cpu_irq", {31'd0, cpu_irq}, {31'd0, e_irq});
    chk("R5 R6 rx_dma_req", {31'd0, rx_dma_req}, {31'd0, e_rx});
    chk("R5 R6 tx_dma_req", {31'd0, tx_dma_req}, {31'd0, e_tx});
    chk("R7 xfer_abort", {31'd0, xfer_abort}, {31'd0, e_ab});
    chk("R7 R8 clk_en", {31'd0, clk_en}, {31'd0, m_clk});
    bus_wr = 0; bus_rd = 0; evt_set = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);
    chk("R1 dma lines", {30'd0, rx_dma_req, tx_dma_req}, 32'd0);
    chk("R1 clk_en", {31'd0, clk_en}, 32'd0);
    cyc(0, 1, 4'd4, 0, 0);
    cyc(0, 1, 4'd3, 0, 0);
    // R2 each event bit sets its request
    for (int i = 0; i < NREQ; i++) cyc(0, 0, 0, 0, 13'(1) << i);
    cyc(0, 1, 4'd4, 0, 0);
    cyc(1, 0, 4'd4, 32'hffff_ffff, 0);
    // R3 mask keeps bits 12:0
    cyc(1, 0, 4'd3, 32'hffff_e001, 0);
    cyc(0, 1, 4'd3, 0, 0);
    cyc(0, 0, 0, 0, 13'h0001);
    cyc(0, 0, 0, 0, 13'h0002);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 4'd3, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 4'd4, 32'h1fff, 0);
    // R5 dma on: FIFO requests steered away from cpu_irq
    cyc(1, 0, 4'd2, 32'h80, 0);
    cyc(0, 0, 0, 0, 13'h0060);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 1, 4'd2, 0, 0);
    // R9 R10 collisions: set wins over clear
    cyc(0, 1, 4'd5, 0, 13'h0020);
    cyc(0, 1, 4'd4, 0, 0);
    cyc(1, 0, 4'd6, 32'h1234, 13'h0040);
    cyc(0, 1, 4'd4, 0, 0);
    cyc(0, 1, 4'd5, 0, 0);
    cyc(1, 0, 4'd6, 0, 0);
    cyc(0, 1, 4'd4, 0, 0);
    cyc(1, 0, 4'd4, 32'h1fff, 13'h1fff);
    cyc(0, 1, 4'd4, 0, 0);
    // R6 dma off
    cyc(1, 0, 4'd2, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 4'd4, 32'h1fff, 0);
    // R7 R8 clock control
    cyc(1, 0, 4'd0, 32'h2, 0);
    cyc(0, 1, 4'd1, 0, 0);
    cyc(1, 0, 4'd0, 32'h1, 0);
    cyc(0, 1, 4'd4, 0, 0);
    cyc(1, 0, 4'd0, 32'h2, 0);
    cyc(0, 1, 4'd4, 0, 0);
    cyc(1, 0, 4'd0, 32'h3, 0);
    cyc(0, 1, 4'd1, 0, 0);
    cyc(0, 1, 4'd0, 0, 0);
    cyc(0, 1, 4'd9, 0, 0);
    // random phase
    void'($urandom(32'h0005_eed1));
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      logic [3:0] a = 4'($urandom_range(0, 7));
      logic [31:0] d = $urandom;
      logic [12:0] ev = ($urandom_range(0, 3) == 0) ? 13'($urandom) : 13'd0;
      if (a == 4'd0 && $urandom_range(0, 3) != 0) d[1:0] = 2'b00;
      if (op < 4)      cyc(0, 1, a, 0, ev);
      else if (op < 8) cyc(1, 0, a, d, ev);
      else             cyc(0, 0, 0, 0, ev);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule